// File: doc/BRIEF.md
# Configurable Synchronous Serial Shifter

The block moves one 8-bit byte per operation over a three-wire synchronous link: a serial data input, a serial data output and a shift clock pin that can be either an output or an input. Software configures it through a small register port. Three control fields select the bit order, full-duplex or receive-only operation, and whether the block masters the shift clock from a programmable divider or follows a clock supplied on the pin. The shift clock idles high. Outgoing data changes after a falling edge, and incoming data is captured on a rising edge.

A write to the data register loads the byte and starts or arms a transfer. With the internal clock the block begins toggling its clock pin at once. With the external clock it waits for edges from the far end. These edges pass through a two-flop synchronizer and are detected in the system clock domain. After the eighth capture the received byte is in the data register, a sticky done flag is set and a one-cycle interrupt pulse is raised.

Top module: `sio_top`

## Requirements
- R1: After reset the control, divider and status registers read 0, the clock pin output is 1 and driven (sck_oe=1), sout is 1 and irq is 0.
- R2: Register map on reg_addr: 0 control, 1 data, 2 divider, 3 status. With control bit0 (clock source) at 0, a data write starts a transfer. sck_o first falls div+1 cycles after the write edge and then toggles every div+1 cycles, for 16 half periods in all.
- R3: With control bit2 at 0 (full duplex), each falling shift-clock edge puts the next transmit bit on sout. Each rising edge captures sin, and after 8 rising edges the data register reads the received byte.
- R4: Control bit1 selects the bit order for both directions: 1 sends and receives bit 7 first, 0 sends and receives bit 0 first.
- R5: With control bit2 at 1 (receive only), sout stays 1 for the whole transfer while reception works as in R3.
- R6: With control bit0 at 1, sck_oe is 0 and shifting follows edges on sck_i. Each edge takes effect within three system clock cycles of the pin change, and a data write only arms the transfer.
- R7: On the eighth rising edge, status bit0 (busy) clears, status bit1 (done) sets and irq is high for exactly one cycle. With the internal clock, sck_o is then left high.
- R8: While busy, writes to the data, control and divider registers are ignored.
- R9: A write to the status register or the start of a new transfer clears done. If a status write falls in the same cycle as completion, done ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output, idles high |
| sck_i | input | 1 | Shift clock from the pin |
| sck_o | output | 1 | Shift clock to the pin |
| sck_oe | output | 1 | Drive enable for the clock pin |
| irq | output | 1 | One-cycle pulse at end of transfer |

## Verification
Two events can land on the same system clock edge: completion of the eighth capture, which sets done, and a software write to the status register, which clears it. The bench uses a divider of 0, so completion falls exactly 16 cycles after the starting write. It places the status write on that edge and requires done to read 1 afterwards. A later status write must still clear it. A data write on that same edge is also judged ignored, because busy is still high when the write is sampled.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_DIV  = 2'd2,
    REG_STAT = 2'd3
  } sio_reg_e;

  // control bits: [2] rx_only, [1] msb_first, [0] clk_ext
  typedef struct packed {
    logic rx_only;
    logic msb_first;
    logic clk_ext;
  } sio_ctrl_t;

  localparam int CTRL_W = 3;
endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output sio_ctrl_t         ctrl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              start_o,
  output logic              clr_done_o
);
  sio_ctrl_t        ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_ctrl, wr_div;

  assign wr_ctrl    = we_i && (addr_i == REG_CTRL) && !busy_i;
  assign wr_div     = we_i && (addr_i == REG_DIV)  && !busy_i;
  assign start_o    = we_i && (addr_i == REG_DATA) && !busy_i;
  assign clr_done_o = we_i && (addr_i == REG_STAT);

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    if (wr_ctrl) ctrl_d = sio_ctrl_t'(wdata_i[CTRL_W-1:0]);
    if (wr_div)  div_d  = wdata_i[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign div_o  = div_q;

  // R8: configuration cannot change while a transfer runs
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(ctrl_q) && $stable(div_q)));
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             clk_ext_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  output logic             fall_ev_o,
  output logic             rise_ev_o
);
  logic [DIV_W-1:0]     cnt_q, cnt_d;
  logic                 sck_q, sck_d;
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_cur, ext_prev, tick;
  logic                 ext_fall, ext_rise, int_fall, int_rise;

  // external clock: synchronizer plus one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], sck_i};
  end

  assign ext_cur  = sync_q[SYNC_STAGES-1];
  assign ext_prev = sync_q[SYNC_STAGES];
  assign ext_fall = busy_i && clk_ext_i &&  ext_prev && !ext_cur;
  assign ext_rise = busy_i && clk_ext_i && !ext_prev &&  ext_cur;

  // internal clock: half period of div+1 system cycles
  assign tick     = busy_i && !clk_ext_i && (cnt_q == div_i);
  assign int_fall = tick &&  sck_q;
  assign int_rise = tick && !sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!busy_i || clk_ext_i) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign fall_ev_o = clk_ext_i ? ext_fall : int_fall;
  assign rise_ev_o = clk_ext_i ? ext_rise : int_rise;
  assign sck_o     = sck_q;
  assign sck_oe    = !clk_ext_i;

  // R2: one shift-clock edge per system cycle at most
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_ev_o && rise_ev_o));
  // R7: generated clock rests high whenever no transfer runs
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> sck_q);
endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_done_i,
  input  logic              msb_first_i,
  input  logic              rx_only_i,
  input  logic              fall_ev_i,
  input  logic              rise_ev_i,
  input  logic              sin_i,
  output logic              sout_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d, sh_next;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d, done_q, done_d;
  logic              sout_q, sout_d, irq_q;
  logic              out_bit, last;

  assign out_bit = msb_first_i ? sh_q[DATA_W-1] : sh_q[0];
  assign sh_next = msb_first_i ? {sh_q[DATA_W-2:0], sin_i}
                               : {sin_i, sh_q[DATA_W-1:1]};
  assign last    = busy_q && rise_ev_i && (cnt_q == LAST_BIT);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = done_q;
    sout_d = sout_q;
    if (start_i) begin
      sh_d   = wdata_i;
      cnt_d  = '0;
      busy_d = 1'b1;
      sout_d = 1'b1;
    end else if (busy_q) begin
      if (fall_ev_i) sout_d = rx_only_i ? 1'b1 : out_bit;
      if (rise_ev_i) begin
        sh_d  = sh_next;
        cnt_d = last ? '0 : cnt_q + 1'b1;
      end
      if (last) begin
        busy_d = 1'b0;
        sout_d = 1'b1;
      end
    end
    if (start_i || clr_done_i) done_d = 1'b0;
    if (last)                  done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sout_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      sout_q <= sout_d;
      irq_q  <= last;
    end
  end

  assign sout_o = sout_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign irq_o  = irq_q;
  assign data_o = sh_q;

  // R7: interrupt is a single-cycle pulse
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R7: pulse coincides with done set and busy clear
  a_r7_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (done_q && !busy_q));
  // R5: receive-only keeps the data line high
  a_r5_rx_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_only_i |-> sout_q);
endmodule

// File: rtl/sio_top.sv
module sio_top
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sin,
  output logic              sout,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              irq
);
  logic              rst_n_s;
  sio_ctrl_t         ctrl;
  logic [DIV_W-1:0]  div;
  logic              start, clr_done, busy, done, fall_ev, rise_ev;
  logic [DATA_W-1:0] shreg;

  sio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sio_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .we_i       (reg_we),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .busy_i     (busy),
    .ctrl_o     (ctrl),
    .div_o      (div),
    .start_o    (start),
    .clr_done_o (clr_done)
  );

  sio_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .busy_i    (busy),
    .clk_ext_i (ctrl.clk_ext),
    .div_i     (div),
    .sck_i     (sck_i),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .fall_ev_o (fall_ev),
    .rise_ev_o (rise_ev)
  );

  sio_shift #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start),
    .wdata_i     (reg_wdata),
    .clr_done_i  (clr_done),
    .msb_first_i (ctrl.msb_first),
    .rx_only_i   (ctrl.rx_only),
    .fall_ev_i   (fall_ev),
    .rise_ev_i   (rise_ev),
    .sin_i       (sin),
    .sout_o      (sout),
    .busy_o      (busy),
    .done_o      (done),
    .irq_o       (irq),
    .data_o      (shreg)
  );

  always_comb begin
    reg_rdata = '0;
    case (sio_reg_e'(reg_addr))
      REG_CTRL: reg_rdata[CTRL_W-1:0] = ctrl;
      REG_DATA: reg_rdata             = shreg;
      REG_DIV:  reg_rdata[DIV_W-1:0]  = div;
      REG_STAT: reg_rdata[1:0]        = {done, busy};
      default:  reg_rdata             = '0;
    endcase
  end
endmodule

// File: tb/sio_top_tb.sv
module sio_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sin = 1'b1;
  logic       sout, sck_o, sck_oe, irq;
  logic       sck_i = 1'b1;
  int         n_cmp = 0;
  int         n_bad = 0;
  int         irq_seen = 0;

  always #10 clk = ~clk;

  sio_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sin(sin), .sout(sout),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic pick(input logic [7:0] v, input int i, input logic msb);
    return msb ? v[7-i] : v[i];
  endfunction

  task automatic ext_edge(input logic lvl);
    sck_i = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R2 actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int         irq_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd2, v); chk("R1 div", v, 8'h00);
    rd(2'd3, v); chk("R1 status", v, 8'h00);
    chk("R1 pins", {4'd0, sck_o, sck_oe, sout, irq}, 8'b0000_1110);

    // sweep: clock source x bit order x duplex mode x pattern
    for (int ext = 0; ext < 2; ext++)
      for (int msb = 0; msb < 2; msb++)
        for (int rxo = 0; rxo < 2; rxo++)
          for (int p = 0; p < 4; p++) begin
            logic [7:0] tx, rxv;
            int         dv;
            tx  = 8'hA5 ^ 8'(p * 8'h1D);
            rxv = ~{tx[3:0], tx[7:4]};
            dv  = p % 3;
            wr(2'd0, {5'd0, rxo[0], msb[0], ext[0]});
            wr(2'd2, 8'(dv));
            chk("R6 sck_oe", {7'd0, sck_oe}, {7'd0, ~ext[0]});
            irq_before = irq_seen;
            wr(2'd1, tx);
            rd(2'd3, v); chk("R9 start clears done", v, 8'h01);
            for (int i = 0; i < 8; i++) begin
              logic eb;
              eb = rxo ? 1'b1 : pick(tx, i, msb[0]);
              if (ext == 0) begin
                repeat (dv + 1) @(posedge clk);
                @(negedge clk);
                chk("R2 sck low", {7'd0, sck_o}, 8'h00);
                chk(rxo ? "R5 sout" : (msb ? "R4 sout" : "R3 sout"), {7'd0, sout}, {7'd0, eb});
                sin = pick(rxv, i, msb[0]);
                repeat (dv + 1) @(posedge clk);
                @(negedge clk);
                chk("R2 sck high", {7'd0, sck_o}, 8'h01);
              end else begin
                ext_edge(1'b0);
                chk(rxo ? "R5 sout ext" : "R6 sout ext", {7'd0, sout}, {7'd0, eb});
                sin = pick(rxv, i, msb[0]);
                ext_edge(1'b1);
              end
            end
            if (ext == 0) chk("R7 irq at end", {7'd0, irq}, 8'h01);
            repeat (2) @(negedge clk);
            rd(2'd3, v); chk("R7 status", v, 8'h02);
            rd(2'd1, v); chk(msb ? "R4 rx" : "R3 rx", v, rxv);
            chk("R7 one irq", 8'(irq_seen - irq_before), 8'd1);
            chk("R7 sck rests", {7'd0, sck_o}, 8'h01);
          end

    // R8: writes while armed (external clock) are ignored
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h05);
    wr(2'd1, 8'hC3);
    wr(2'd1, 8'h3C);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h07);
    rd(2'd0, v); chk("R8 ctrl held", v, 8'h01);
    rd(2'd2, v); chk("R8 div held", v, 8'h05);
    for (int i = 0; i < 8; i++) begin
      ext_edge(1'b0);
      chk("R8 first byte sent", {7'd0, sout}, {7'd0, pick(8'hC3, i, 1'b0)});
      sin = i[0];
      ext_edge(1'b1);
    end
    rd(2'd1, v); chk("R8 rx", v, 8'hAA);

    // R9: status clear coinciding with completion, divider 0
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h5A);
    repeat (15) @(negedge clk);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R9 set wins", v, 8'h02);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R9 clear", v, 8'h00);

    // R8: data write on the completion edge is ignored
    wr(2'd1, 8'h81);
    repeat (15) @(negedge clk);
    wr(2'd1, 8'h42);
    rd(2'd3, v); chk("R8 late write ignored", v, 8'h02);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule